// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a word-addressed memory that keeps one presence flag beside every data word. Producers and consumers use it to synchronise on single words. A read of a word that holds data returns that data on the next cycle, as any memory read would. A read of a word that has not yet been produced is not answered with stale contents. It is parked in a small table of waiting reads and answered only when a later write supplies the word. An address can therefore be handed to consumers before its value exists, and only the reads that need the value wait for it.

Requests arrive on one port with a valid/ready handshake, an operation code, an address, write data and a tag. Every response carries the tag of the read that caused it, so a requester can match completions that return out of order. A clear operation marks a word as empty again, which lets the same location be reused for the next round of a computation. When the table of waiting reads is full, a new read of an empty word is held off with ready low. Other requests keep flowing.

Top module: `fe_mem`

## Requirements
- R1: After reset every word is empty, `rsp_valid` is low and `req_ready` is high.
- R2: A read (`req_op` = 0) accepted while the word is full gives `rsp_valid` high on the following cycle, with the stored word on `rsp_data` and the request's tag on `rsp_tag`.
- R3: A read accepted while the word is empty produces no response until a write to that address.
- R4: A write (`req_op` = 1) stores `req_wdata` and marks the word full. Writes, clears and code 3 never produce a response.
- R5: A write to an address with parked reads releases every one of them with the written data. The responses come one per cycle in the order the reads arrived, the first on the second cycle after the write is accepted.
- R6: While parked reads are being released, `req_ready` is low.
- R7: With all `PEND_DEPTH` table entries in use, a read of an empty word sees `req_ready` low and is not taken. Writes, clears and reads of full words are still accepted.
- R8: A clear (`req_op` = 2) marks the word empty, so a later read parks until the next write.
- R9: A write to a full word replaces its data. Code 3 is accepted and changes nothing.
- R10: A write releases only the reads parked on its own address. Reads parked on other addresses stay parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_op | input | 2 | 0 read, 1 write, 2 clear to empty, 3 no operation |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for a write |
| req_tag | input | TAG_W | Tag returned with the response to a read |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_data | output | DATA_W | Word returned to the read |

## Verification
The bench writes every address and then reads it back, checking data, tag and one-cycle latency. A design that lost the presence flag or mixed up addresses fails there. It fills the waiting table with three reads of one word and one of another, then confirms four things: a fifth read of an empty word is refused, writes and reads of full words still pass, and the write releases exactly the three matching tags in arrival order on consecutive cycles. A design that released out of order, released the wrong address or kept ready high during the release would show wrong tags, wrong cycles or an extra response. Clears, overwrites, code 3 and the refused read are each checked by parking or not parking a later read and counting the responses.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_EMPTY = 2'd2,
      OP_NONE  = 2'd3
   } fe_op_e;
endpackage

// File: rtl/fe_word_store.sv
module fe_word_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_full
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [WORDS];
   logic [WORDS-1:0]  full_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      full_q       <= '0;
      else if (wr_en)  full_q[addr] <= 1'b1;
      else if (clr_en) full_q[addr] <= 1'b0;
   end

   assign rd_data = mem_q[addr];
   assign rd_full = full_q[addr];

   AST_WRITE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> full_q[$past(addr)]); // R4
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !wr_en) |=> !full_q[$past(addr)]); // R8
endmodule

// File: rtl/fe_pend_table.sv
module fe_pend_table #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [TAG_W-1:0]  push_tag,
   input  logic              fill,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              pop,
   output logic              full,
   output logic              any_go,
   output logic [TAG_W-1:0]  head_tag,
   output logic [DATA_W-1:0] head_data
);
   // Entries are kept packed from index 0 (oldest) upward; removal shifts down.
   logic              v_q  [DEPTH];
   logic              go_q [DEPTH];
   logic [ADDR_W-1:0] a_q  [DEPTH];
   logic [TAG_W-1:0]  t_q  [DEPTH];
   logic [DATA_W-1:0] d_q  [DEPTH];

   logic [DEPTH-1:0] sel;
   logic [DEPTH-1:0] after;

   always_comb begin
      logic found;
      found     = 1'b0;
      sel       = '0;
      after     = '0;
      head_tag  = '0;
      head_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (go_q[i] && !found) begin
            sel[i]    = 1'b1;
            head_tag  = t_q[i];
            head_data = d_q[i];
         end
         if (go_q[i]) found = 1'b1;
         after[i] = found;
      end
      any_go = found;
   end

   assign full = v_q[DEPTH-1];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic              up_v;
      logic              up_go;
      logic [ADDR_W-1:0] up_a;
      logic [TAG_W-1:0]  up_t;
      logic [DATA_W-1:0] up_d;
      logic              prev_v;
      logic              shift;
      logic              slot;
      logic              hit;

      if (i < DEPTH - 1) begin : g_mid
         assign up_v  = v_q[i+1];
         assign up_go = go_q[i+1];
         assign up_a  = a_q[i+1];
         assign up_t  = t_q[i+1];
         assign up_d  = d_q[i+1];
      end else begin : g_last
         assign up_v  = 1'b0;
         assign up_go = 1'b0;
         assign up_a  = '0;
         assign up_t  = '0;
         assign up_d  = '0;
      end

      if (i == 0) begin : g_first
         assign prev_v = 1'b1;
      end else begin : g_rest
         assign prev_v = v_q[i-1];
      end

      assign shift = pop && after[i];
      assign slot  = push && !v_q[i] && prev_v;
      assign hit   = fill && v_q[i] && !go_q[i] && (a_q[i] == fill_addr);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q[i]  <= 1'b0;
            go_q[i] <= 1'b0;
         end else if (shift) begin
            v_q[i]  <= up_v;
            go_q[i] <= up_go;
         end else if (slot) begin
            v_q[i]  <= 1'b1;
            go_q[i] <= 1'b0;
         end else if (hit) begin
            go_q[i] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (shift) begin
            a_q[i] <= up_a;
            t_q[i] <= up_t;
            d_q[i] <= up_d;
         end else if (slot) begin
            a_q[i] <= push_addr;
            t_q[i] <= push_tag;
         end else if (hit) begin
            d_q[i] <= fill_data;
         end
      end
   end

   AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R7
   AST_PUSH_NOT_DRAINING: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !any_go); // R6
   AST_POP_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> any_go); // R5
   AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R5
endmodule

// File: rtl/fe_mem.sv
module fe_mem
   import fe_mem_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int TAG_W      = 4,
   parameter int PEND_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("fe_mem: ADDR_W out of range");
   end
   if (PEND_DEPTH < 1 || PEND_DEPTH > 64) begin : g_bad_depth
      $error("fe_mem: PEND_DEPTH out of range");
   end
   if (DATA_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("fe_mem: DATA_W and TAG_W must be positive");
   end

   logic              st_full;
   logic [DATA_W-1:0] st_data;
   logic              pt_full;
   logic              pt_any_go;
   logic [TAG_W-1:0]  pt_tag;
   logic [DATA_W-1:0] pt_data;

   logic is_read, fire, do_hit, do_park, do_write, do_clear;

   assign is_read   = (req_op == OP_READ);
   assign req_ready = !pt_any_go && !(is_read && !st_full && pt_full);
   assign fire      = req_valid && req_ready;
   assign do_hit    = fire && is_read && st_full;
   assign do_park   = fire && is_read && !st_full;
   assign do_write  = fire && (req_op == OP_WRITE);
   assign do_clear  = fire && (req_op == OP_EMPTY);

   fe_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (do_write),
      .clr_en  (do_clear),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .rd_data (st_data),
      .rd_full (st_full)
   );

   fe_pend_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
                   .DEPTH(PEND_DEPTH)) pend_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (do_park),
      .push_addr (req_addr),
      .push_tag  (req_tag),
      .fill      (do_write),
      .fill_addr (req_addr),
      .fill_data (req_wdata),
      .pop       (pt_any_go),
      .full      (pt_full),
      .any_go    (pt_any_go),
      .head_tag  (pt_tag),
      .head_data (pt_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_tag   <= '0;
         rsp_data  <= '0;
      end else if (pt_any_go) begin
         rsp_valid <= 1'b1;
         rsp_tag   <= pt_tag;
         rsp_data  <= pt_data;
      end else if (do_hit) begin
         rsp_valid <= 1'b1;
         rsp_tag   <= req_tag;
         rsp_data  <= st_data;
      end else begin
         rsp_valid <= 1'b0;
      end
   end

   AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      do_hit |=> (rsp_valid && rsp_tag == $past(req_tag) && rsp_data == $past(st_data))); // R2
   AST_PARK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      do_park |=> !rsp_valid); // R3
   AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !is_read) |=> !rsp_valid); // R4
   AST_DRAIN_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      pt_any_go |-> !req_ready); // R6
   AST_FULL_TABLE_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_read && !st_full && pt_full) |-> !req_ready); // R7
endmodule

// File: tb/fe_mem_tb_top.sv
module fe_mem_tb_top;
   localparam time TB_CLK = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_tag = '0;
   logic        rsp_valid;
   logic [3:0]  rsp_tag;
   logic [31:0] rsp_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int acc_cyc = 0;
   int n = 0;
   int lg_tag [1024];
   logic [31:0] lg_data [1024];
   int lg_cyc [1024];

   fe_mem dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
   );

   always #(TB_CLK/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && rsp_valid && n < 1024) begin
         lg_tag[n]  = int'(rsp_tag);
         lg_data[n] = rsp_data;
         lg_cyc[n]  = cyc;
         n = n + 1;
      end
   end

   function automatic logic [31:0] dat(input int a);
      return (32'(a) + 32'd3) * 32'h0100_0193 ^ 32'hC3A5_0F96;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
      #2;
   endtask

   task automatic send(input logic [1:0] op, input int addr, input logic [31:0] d,
                       input logic [3:0] tg);
      logic rdy;
      req_op = op; req_addr = 8'(addr); req_wdata = d; req_tag = tg; req_valid = 1'b1;
      do begin
         #1 rdy = req_ready;
         @(posedge clk);
         if (!rdy) @(negedge clk);
      end while (!rdy);
      @(negedge clk);
      req_valid = 1'b0;
      acc_cyc = cyc;
   endtask

   task automatic try_once(input logic [1:0] op, input int addr, input logic [31:0] d,
                           input logic [3:0] tg, output logic rdy);
      req_op = op; req_addr = 8'(addr); req_wdata = d; req_tag = tg; req_valid = 1'b1;
      #1 rdy = req_ready;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      acc_cyc = cyc;
   endtask

   initial begin
      #(TB_CLK * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n0;
      logic rdy;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      check("R1 rsp_valid after reset", rsp_valid, 0);
      check("R1 req_ready after reset", req_ready, 1);

      // R3 / R1: read of a never-written word parks
      n0 = n;
      send(2'd0, 3, 0, 4'd9);
      idle(5);
      check("R3 no response for empty word", n, n0);
      send(2'd1, 3, 32'hDEAD_0003, 0);
      idle(4);
      check("R5 single release count", n, n0 + 1);
      check("R5 release tag", lg_tag[n0], 9);
      check("R5 release data", lg_data[n0], 32'hDEAD_0003);
      check("R5 release cycle", lg_cyc[n0], acc_cyc + 1);

      // R4: full write sweep, no responses
      n0 = n;
      for (int a = 0; a < 256; a++) send(2'd1, a, dat(a), 0);
      idle(2);
      check("R4 writes silent", n, n0);

      // R2: full read sweep
      for (int a = 0; a < 256; a++) begin
         int k;
         k = n;
         send(2'd0, a, 0, 4'(a));
         idle(1);
         check("R2 hit count", n, k + 1);
         check("R2 hit data", lg_data[k], dat(a));
         check("R2 hit tag", lg_tag[k], a % 16);
         check("R2 hit latency", lg_cyc[k], acc_cyc);
      end

      // R7 / R5 / R6 / R10: fill the waiting table
      send(2'd2, 10, 0, 0);
      send(2'd2, 20, 0, 0);
      send(2'd2, 30, 0, 0);
      n0 = n;
      send(2'd0, 10, 0, 4'd1);
      send(2'd0, 10, 0, 4'd2);
      send(2'd0, 10, 0, 4'd3);
      send(2'd0, 20, 0, 4'd4);
      idle(3);
      check("R3 four parked silent", n, n0);
      try_once(2'd0, 30, 0, 4'd7, rdy);
      check("R7 read of empty refused when table full", rdy, 0);
      try_once(2'd1, 40, 32'h4040_4040, 0, rdy);
      check("R7 write accepted when table full", rdy, 1);
      try_once(2'd0, 40, 0, 4'd8, rdy);
      check("R7 full-word read accepted when table full", rdy, 1);
      idle(1);
      check("R7 hit response tag", lg_tag[n - 1], 8);
      check("R9 hit sees new data", lg_data[n - 1], 32'h4040_4040);
      n0 = n;
      send(2'd1, 10, 32'hABCD_0010, 0);
      #1 check("R6 ready low during release", req_ready, 0);
      idle(5);
      check("R10 only matching reads released", n, n0 + 3);
      for (int j = 0; j < 3; j++) begin
         check("R5 order tag", lg_tag[n0 + j], j + 1);
         check("R5 release data", lg_data[n0 + j], 32'hABCD_0010);
         check("R5 release cycle", lg_cyc[n0 + j], acc_cyc + 1 + j);
      end
      n0 = n;
      send(2'd1, 20, 32'h2020_0020, 0);
      idle(3);
      check("R10 other reader released later", n, n0 + 1);
      check("R10 other reader tag", lg_tag[n0], 4);
      check("R10 other reader data", lg_data[n0], 32'h2020_0020);
      n0 = n;
      send(2'd1, 30, 32'h3030_0030, 0);
      idle(3);
      check("R7 refused read was not parked", n, n0);

      // R8: clear makes a word empty again
      send(2'd1, 50, 32'h5050_0001, 0);
      send(2'd2, 50, 0, 0);
      n0 = n;
      send(2'd0, 50, 0, 4'd5);
      idle(4);
      check("R8 read after clear parks", n, n0);
      send(2'd1, 50, 32'h5050_0002, 0);
      idle(3);
      check("R8 release count", n, n0 + 1);
      check("R8 release data", lg_data[n0], 32'h5050_0002);

      // R9: overwrite and code 3
      send(2'd1, 60, 32'h6060_0001, 0);
      send(2'd1, 60, 32'h6060_0002, 0);
      n0 = n;
      send(2'd0, 60, 0, 4'd11);
      idle(1);
      check("R9 overwrite data", lg_data[n0], 32'h6060_0002);
      send(2'd2, 70, 0, 0);
      send(2'd3, 70, 32'h7777_7777, 0);
      n0 = n;
      send(2'd0, 70, 0, 4'd6);
      idle(4);
      check("R9 code 3 does not fill", n, n0);
      send(2'd1, 70, 32'h7070_0070, 0);
      idle(3);
      check("R9 release after code 3", lg_data[n0], 32'h7070_0070);
      check("R9 release tag", lg_tag[n0], 6);
      send(2'd3, 60, 32'h1111_1111, 0);
      n0 = n;
      send(2'd0, 60, 0, 4'd12);
      idle(1);
      check("R9 code 3 keeps data", lg_data[n0], 32'h6060_0002);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule